// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiator side of a synchronous bus where address and data share one set of lines. A local client hands it a command code, a start byte address and a word count with a single start pulse. The block asks the arbiter for the bus. Once granted, it drives one address cycle and then moves data words with two-sided flow control. A word moves only on a rising edge where the initiator-ready and target-ready lines are both high. The burst length is not limited by the bus.

The cycle-valid line stays high through the address phase and all data phases except the last one. Its drop tells the target that exactly one more word is due. Reads get a turnaround cycle between the address and the first data phase, because the shared lines change driver there. A target can cut a burst short with its stop line, and the arbiter can cut it short by taking the grant away. In either case the block keeps the remaining count and the next address. It then asks for the bus again and continues with a fresh address phase. The job is complete only when every word has moved.

Top module: `burst_initiator`

## Requirements
- R1: After reset the cycle-valid, initiator-ready, busy, request, done and drive-enable outputs are low. A start pulse is accepted only while not busy and with a nonzero count. A start with count zero, or a start while busy, leaves the running job and the outputs unchanged.
- R2: While a job has words left and no bus tenure is in progress, `bus_req_o` is high. In the cycle after the grant is sampled high in that state, the address phase shows cycle-valid high, initiator-ready low, drive enable high, the current address on `ad_o` and the command on `cmd_o`.
- R3: A word moves on each rising edge where `init_rdy_o` and `tgt_rdy_i` are both high, and `xfer_o` marks that cycle. The address advances by DATA_W/8 bytes per word, and every counted word reaches the bus exactly once.
- R4: `bus_cyc_o` is low during the data phase of the final word of a tenure and high in every earlier data phase.
- R5: `init_rdy_o` is low in the cycle after the final transfer of a tenure. At least one cycle with both cycle-valid and initiator-ready low separates two tenures.
- R6: For a read, the cycle after the address phase has the drive enable and initiator-ready low. Read words are returned on `rd_data_o` in the cycles where `xfer_o` is high. For a write, `ad_o` carries `wr_data_i` with the drive enable high during each data phase.
- R7: If the target stop line is sampled high in a data phase, the tenure ends: both cycle-valid and initiator-ready are low in the next cycle. A word moves on that edge only if target-ready was also high. The remaining words follow in a later tenure whose address phase carries the next unsent address.
- R8: If the grant is sampled low during a tenure, cycle-valid is low from the next cycle. Exactly one more word then moves, the tenure ends, and the rest resumes after a new grant.
- R9: `done_o` pulses for one cycle, in the cycle after the last word of the job moves, and `busy_o` is low in that cycle.
- R10: Bit 0 of the command code selects the direction: 1 means write (the initiator drives data) and 0 means read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all signals sampled on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse for a new job |
| cmd_i | input | CMD_W | Command code; bit 0 = write |
| addr_i | input | AD_W | Start byte address |
| count_i | input | CNT_W | Number of words in the job |
| wr_data_i | input | AD_W | Write word for the current data phase |
| busy_o | output | 1 | Job has words left |
| done_o | output | 1 | One-cycle pulse after the last word |
| xfer_o | output | 1 | A word moves on the coming edge |
| rd_data_o | output | AD_W | Read word, valid with xfer_o |
| bus_req_o | output | 1 | Request to the arbiter |
| bus_grant_i | input | 1 | Grant from the arbiter |
| bus_cyc_o | output | 1 | Cycle-valid, high until the last data phase |
| init_rdy_o | output | 1 | Initiator ready for data |
| tgt_rdy_i | input | 1 | Target ready for data |
| tgt_stop_i | input | 1 | Target asks to end the tenure |
| ad_o | output | AD_W | Address / write data to the shared lines |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| ad_i | input | AD_W | Read data from the shared lines |
| cmd_o | output | CMD_W | Command during the address phase, else zero |

## Verification
Several rules are checked on every cycle. Cycle-valid never comes back while a final data phase is open. Initiator-ready falls after the last transfer and after a stop. Cycle-valid falls after a lost grant. Address phases start from an idle bus, reads get their turnaround, and the request is never raised during a tenure. Only the bench scenarios can show the data-side results. These are the word values and their order, the resume address after a stop or a lost grant, the number of tenures per job, and the total word count under stall patterns.

// File: rtl/burst_pkg.sv
// Shared types for the burst initiator: the bus phase of the sequencer.
package burst_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_TURN = 2'd2,
        PH_DATA = 2'd3
    } phase_t;
endpackage

// File: rtl/burst_track.sv
// Job tracker: holds command, next byte address and words left.
// Assumes load_i and step_i are never high together (load only when idle).
module burst_track #(
    parameter int AD_W  = 32,
    parameter int CNT_W = 8,
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [AD_W-1:0]  addr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             step_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic [AD_W-1:0]  addr_o,
    output logic             pending_o,
    output logic             rem_one_o,
    output logic             rem_two_o
);
    localparam int STEP = AD_W / 8;

    logic [CNT_W-1:0] rem_q;
    logic [AD_W-1:0]  addr_q;
    logic [CMD_W-1:0] cmd_q;

    // Load a job, or advance address and count after each moved word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            addr_q <= '0;
            cmd_q  <= '0;
        end else if (load_i) begin
            rem_q  <= count_i;
            addr_q <= addr_i;
            cmd_q  <= cmd_i;
        end else if (step_i) begin
            rem_q  <= rem_q - CNT_W'(1);
            addr_q <= addr_q + AD_W'(STEP);
        end
    end

    assign cmd_o     = cmd_q;
    assign addr_o    = addr_q;
    assign pending_o = (rem_q != '0);
    assign rem_one_o = (rem_q == CNT_W'(1));
    assign rem_two_o = (rem_q == CNT_W'(2));
endmodule

// File: rtl/burst_seq.sv
// Phase sequencer: idle, address, read turnaround, data.
// Drives cycle-valid and initiator-ready from registered state; ends a
// tenure on the final word, on target stop, or one word after grant loss.
module burst_seq
    import burst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pending_i,
    input  logic   rem_one_i,
    input  logic   rem_two_i,
    input  logic   write_i,
    input  logic   gnt_i,
    input  logic   trdy_i,
    input  logic   stop_i,
    output phase_t phase_o,
    output logic   frame_o,
    output logic   irdy_o,
    output logic   xfer_o,
    output logic   done_o
);
    phase_t phase_q;
    logic   last_q;
    logic   done_q;
    logic   xfer;

    assign xfer = (phase_q == PH_DATA) && trdy_i;

    // Advance the phase and track whether the current data phase is final.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            last_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (pending_i && gnt_i) begin
                        phase_q <= PH_ADDR;
                        last_q  <= rem_one_i;
                    end
                end
                PH_ADDR: begin
                    phase_q <= write_i ? PH_DATA : PH_TURN;
                    if (!gnt_i) last_q <= 1'b1;
                end
                PH_TURN: begin
                    phase_q <= PH_DATA;
                    if (!gnt_i) last_q <= 1'b1;
                end
                default: begin
                    if ((xfer && (last_q || rem_one_i)) || stop_i) begin
                        phase_q <= PH_IDLE;
                        last_q  <= 1'b0;
                    end else begin
                        if (xfer && rem_two_i) last_q <= 1'b1;
                        if (!gnt_i)            last_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // One-cycle completion pulse after the job's last word moves.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= xfer && rem_one_i;
    end

    assign phase_o = phase_q;
    assign frame_o = (phase_q == PH_ADDR) ||
                     (((phase_q == PH_TURN) || (phase_q == PH_DATA)) && !last_q);
    assign irdy_o  = (phase_q == PH_DATA);
    assign xfer_o  = xfer;
    assign done_o  = done_q;
endmodule

// File: rtl/burst_drive.sv
// Shared-line driver: address and command in the address phase, write
// data in write data phases, lines released otherwise.
module burst_drive
    import burst_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CMD_W = 4
) (
    input  phase_t           phase_i,
    input  logic             write_i,
    input  logic [AD_W-1:0]  addr_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [AD_W-1:0]  wr_data_i,
    output logic [AD_W-1:0]  ad_o,
    output logic             ad_oe_o,
    output logic [CMD_W-1:0] cmd_o
);
    // Select what goes onto the shared lines for the current phase.
    always_comb begin
        ad_o    = '0;
        ad_oe_o = 1'b0;
        cmd_o   = '0;
        if (phase_i == PH_ADDR) begin
            ad_o    = addr_i;
            ad_oe_o = 1'b1;
            cmd_o   = cmd_i;
        end else if (phase_i == PH_DATA && write_i) begin
            ad_o    = wr_data_i;
            ad_oe_o = 1'b1;
        end
    end
endmodule

// File: rtl/burst_initiator.sv
// Burst initiator top: accepts a job, requests the bus, runs tenures
// until every word has moved. Assumes one job at a time; target and
// arbiter signals are synchronous to clk.
module burst_initiator
    import burst_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CNT_W = 8,
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [AD_W-1:0]  addr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [AD_W-1:0]  wr_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             xfer_o,
    output logic [AD_W-1:0]  rd_data_o,
    output logic             bus_req_o,
    input  logic             bus_grant_i,
    output logic             bus_cyc_o,
    output logic             init_rdy_o,
    input  logic             tgt_rdy_i,
    input  logic             tgt_stop_i,
    output logic [AD_W-1:0]  ad_o,
    output logic             ad_oe_o,
    input  logic [AD_W-1:0]  ad_i,
    output logic [CMD_W-1:0] cmd_o
);
    phase_t           phase;
    logic             pending, rem_one, rem_two, load, xfer;
    logic [CMD_W-1:0] cmd_q;
    logic [AD_W-1:0]  addr_q;

    assign load = start_i && !pending && (count_i != '0);

    burst_track #(.AD_W(AD_W), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_track (
        .clk(clk), .rst_n(rst_n), .load_i(load), .cmd_i(cmd_i),
        .addr_i(addr_i), .count_i(count_i), .step_i(xfer),
        .cmd_o(cmd_q), .addr_o(addr_q), .pending_o(pending),
        .rem_one_o(rem_one), .rem_two_o(rem_two)
    );

    burst_seq u_seq (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .rem_one_i(rem_one),
        .rem_two_i(rem_two), .write_i(cmd_q[0]), .gnt_i(bus_grant_i),
        .trdy_i(tgt_rdy_i), .stop_i(tgt_stop_i), .phase_o(phase),
        .frame_o(bus_cyc_o), .irdy_o(init_rdy_o), .xfer_o(xfer),
        .done_o(done_o)
    );

    burst_drive #(.AD_W(AD_W), .CMD_W(CMD_W)) u_drive (
        .phase_i(phase), .write_i(cmd_q[0]), .addr_i(addr_q),
        .cmd_i(cmd_q), .wr_data_i(wr_data_i), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .cmd_o(cmd_o)
    );

    assign busy_o    = pending;
    assign xfer_o    = xfer;
    assign rd_data_o = ad_i;
    assign bus_req_o = pending && (phase == PH_IDLE);
endmodule

// File: rtl/burst_initiator_checker.sv
// Protocol checker for burst_initiator, attached by bind; ports only.
module burst_initiator_checker #(
    parameter int CMD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cyc_o,
    input logic             init_rdy_o,
    input logic             tgt_rdy_i,
    input logic             tgt_stop_i,
    input logic             bus_grant_i,
    input logic             ad_oe_o,
    input logic [CMD_W-1:0] cmd_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             bus_req_o,
    input logic             xfer_o
);
    assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc_o) |-> (!init_rdy_o && ad_oe_o));
    assert_req_outside_tenure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (!bus_cyc_o && !init_rdy_o && busy_o));
    assert_xfer_in_job_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> (busy_o && init_rdy_o));
    assert_final_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rdy_o && !bus_cyc_o) |=> !bus_cyc_o);
    assert_release_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rdy_o && !bus_cyc_o && tgt_rdy_i) |=> !init_rdy_o);
    assert_read_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_cyc_o) && !cmd_o[0]) |=> (!ad_oe_o && !init_rdy_o));
    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rdy_o && tgt_stop_i) |=> (!bus_cyc_o && !init_rdy_o));
    assert_grant_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rdy_o && !bus_grant_i) |=> !bus_cyc_o);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind burst_initiator burst_initiator_checker #(.CMD_W(CMD_W)) u_chk (.*);

// File: tb/burst_initiator_test.sv
module burst_initiator_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [7:0]  cnt;
        logic [3:0]  mask;     // target ready per data cycle (index mod 4)
        logic [7:0]  stop_at;  // word index at which stop is raised once
        logic [7:0]  gdrop;    // word index at which grant is removed once
        logic [3:0]  tenures;  // expected address phases
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'h7, 32'h0000_1000, 8'd1, 4'hF, 8'hFF, 8'hFF, 4'd1},
        '{4'h6, 32'h0000_2000, 8'd4, 4'hF, 8'hFF, 8'hFF, 4'd1},
        '{4'h7, 32'h0000_3000, 8'd6, 4'h5, 8'hFF, 8'hFF, 4'd1},
        '{4'h6, 32'h0000_4000, 8'd5, 4'h3, 8'd2,  8'hFF, 4'd2},
        '{4'h7, 32'h0000_5000, 8'd4, 4'hF, 8'd1,  8'hFF, 4'd2},
        '{4'h6, 32'h0000_6000, 8'd3, 4'hE, 8'd0,  8'hFF, 4'd2},
        '{4'h7, 32'h0000_7000, 8'd5, 4'hF, 8'hFF, 8'd1,  4'd2},
        '{4'h6, 32'h0000_8000, 8'd6, 4'hB, 8'hFF, 8'd2,  4'd2},
        '{4'h6, 32'h0000_9000, 8'd1, 4'hF, 8'hFF, 8'hFF, 4'd1}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0, gnt = 1'b1, trdy = 1'b0, stop = 1'b0;
    logic [3:0]  cmd = '0;
    logic [31:0] addr = '0, wr_data = '0, ad_i = '0;
    logic [7:0]  count = '0;
    logic        busy, done, xfer, bus_req, frame, irdy, ad_oe;
    logic [31:0] rd_data, ad_o;
    logic [3:0]  cmd_o;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_initiator uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
        .count_i(count), .wr_data_i(wr_data), .busy_o(busy), .done_o(done),
        .xfer_o(xfer), .rd_data_o(rd_data), .bus_req_o(bus_req),
        .bus_grant_i(gnt), .bus_cyc_o(frame), .init_rdy_o(irdy),
        .tgt_rdy_i(trdy), .tgt_stop_i(stop), .ad_o(ad_o), .ad_oe_o(ad_oe),
        .ad_i(ad_i), .cmd_o(cmd_o)
    );

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] wr_pat(input int i);
        return 32'hC0DE_0000 + 32'(i);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Runs one job against a modelled target; called at a negedge.
    task automatic run_job(input vec_t v);
        int words = 0, ten = 0, dcyc = 0, guard = 0;
        bit stopped = 0, gused = 0, forced = 0, after_addr = 0;
        bit prev_f = 0, prev_i = 0, final_prev = 0, seen_done = 0;
        cmd = v.cmd; addr = v.addr; count = v.cnt; start = 1'b1; gnt = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && guard < 400) begin
            guard++;
            trdy = 1'b0; stop = 1'b0;
            if (final_prev) check(!irdy, "R5 ready released after tenure end", 32'(irdy), 32'd0);
            final_prev = 0;
            if (done) begin
                seen_done = 1;
                check(!busy, "R9 busy low with done", 32'(busy), 32'd0);
                check(words == int'(v.cnt), "R3 word count of job", 32'(words), 32'(v.cnt));
                check(ten == int'(v.tenures), "R7/R8 tenure count", 32'(ten), 32'(v.tenures));
            end else begin
                if (after_addr) begin
                    if (!v.cmd[0])
                        check(!ad_oe && !irdy, "R6 read turnaround", {30'd0, ad_oe, irdy}, 32'd0);
                    else
                        check(irdy && ad_oe, "R10 write data phase follows address", {30'd0, ad_oe, irdy}, 32'd3);
                    after_addr = 0;
                end
                if (frame && !prev_f && !prev_i) begin
                    ten++;
                    check(ad_o == v.addr + 32'(4*words), "R2 address phase address", ad_o, v.addr + 32'(4*words));
                    check(cmd_o == v.cmd && !irdy, "R2 address phase command", {28'd0, cmd_o}, {28'd0, v.cmd});
                    dcyc = 0; forced = 0; after_addr = 1;
                end
                if (!frame && !irdy && !gnt && busy) gnt = 1'b1;
                wr_data = wr_pat(words);
                if (irdy) begin
                    trdy = v.mask[dcyc % 4];
                    dcyc++;
                    if (!stopped && words == int'(v.stop_at)) begin stop = 1'b1; stopped = 1; end
                    if (!gused && words == int'(v.gdrop)) begin gnt = 1'b0; gused = 1; end
                    ad_i = rd_pat(v.addr + 32'(4*words));
                    #1;
                    if (trdy) begin
                        check(xfer, "R3 transfer flagged", 32'(xfer), 32'd1);
                        check(frame == ((words != int'(v.cnt) - 1) && !forced), "R4/R8 cycle-valid on data phase",
                              32'(frame), 32'((words != int'(v.cnt) - 1) && !forced));
                        if (v.cmd[0])
                            check(ad_o == wr_pat(words) && ad_oe, "R6 write word on bus", ad_o, wr_pat(words));
                        else
                            check(rd_data == rd_pat(v.addr + 32'(4*words)), "R6 read word returned",
                                  rd_data, rd_pat(v.addr + 32'(4*words)));
                        if (!frame || stop) final_prev = 1;
                        words++;
                    end else begin
                        check(!xfer, "R3 no transfer while target stalls", 32'(xfer), 32'd0);
                        if (stop) final_prev = 1;
                    end
                    if (!gnt) forced = 1;
                end
                prev_f = frame; prev_i = irdy;
                @(negedge clk);
            end
        end
        trdy = 1'b0; stop = 1'b0; gnt = 1'b1;
        if (!seen_done) check(0, "R9 job never completed", 32'(words), 32'(v.cnt));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!frame && !irdy && !busy && !bus_req && !done && !ad_oe, "R1 reset outputs",
              {26'd0, frame, irdy, busy, bus_req, done, ad_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven jobs
        for (int i = 0; i < 9; i++) run_job(VECS[i]);

        // R1: zero count ignored
        cmd = 4'h7; addr = 32'hA000; count = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(!busy && !bus_req && !frame, "R1 zero count ignored", {29'd0, busy, bus_req, frame}, 32'd0);
            @(negedge clk);
        end

        // R1/R2: start while busy is ignored
        gnt = 1'b0;
        cmd = 4'h7; addr = 32'hB000; count = 8'd2; start = 1'b1;
        @(negedge clk);
        check(busy && bus_req && !frame, "R2 request while waiting for grant", {29'd0, busy, bus_req, frame}, 32'd6);
        cmd = 4'h6; addr = 32'hC000; count = 8'd9;
        @(negedge clk);
        start = 1'b0;
        gnt = 1'b1;
        @(negedge clk);
        check(frame && ad_o == 32'hB000 && cmd_o == 4'h7, "R1 start while busy ignored", ad_o, 32'hB000);
        n = 0;
        trdy = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (xfer) n++;
        end
        trdy = 1'b0;
        check(n == 2 && !busy, "R1 first job count kept", 32'(n), 32'd2);

        summary();
        $finish;
    end
endmodule